// File: doc/BRIEF.md
# Predicate Redirection Table

This block turns a small set of programmable predication entries into two lookup tables that are read in the same cycle. One table is indexed by integer register number and the other by floating-point register number. Each entry names a key register and an integer register that holds the predicate bits for operations that use the key. It also carries a flag to complement those bits and a flag that asks for masked-off elements to be zeroed.

Software writes entries through the write port and then pulses the rebuild input. The block then spends one cycle clearing both tables and one cycle on each entry, in ascending entry order, and holds `busy` high the whole time. After that, an issue stage presents a register number and a class selector on the lookup port. The block drives the predicate register number to an external integer register file and returns the effective mask and the zero flag in the same cycle. A register with no enabled table slot yields a mask of all ones.

Top module: `pred_map_table`

## Requirements
- R1: After reset `busy` is 0, and every lookup returns an all-ones mask with `lk_zero` 0.
- R2: A write with `wr_en` high while idle stores the entry at `wr_idx`. Lookups do not change until a rebuild completes.
- R3: A `rebuild` pulse sampled while idle sets `busy` after that edge and keeps it high for exactly 1 + 16 = 17 cycles (one clear cycle, then one cycle per entry).
- R4: Each rebuild first clears every slot of both tables. An entry written with `wr_used` = 0 enables nothing, so a register it previously covered falls back to the all-ones mask.
- R5: For an enabled slot with invert 0, `rf_addr` equals the entry's predicate register and `lk_mask` equals `rf_data`.
- R6: For an enabled slot with invert 1, `lk_mask` is the bitwise complement of `rf_data`.
- R7: `wr_is_fp` = 0 programs the integer table and 1 the FP table. `lk_is_fp` selects which table is looked up. The predicate is always read through the single integer register file port `rf_addr`/`rf_data`.
- R8: When two used entries of the same class share a key, the entry with the higher index decides the result.
- R9: `lk_zero` returns the zero flag of the matched entry, and is 0 when the slot is not enabled.
- R10: `wr_en` and `rebuild` are ignored while `busy` is high. The stored entries and the rebuild length are unaffected.
- R11: A lookup of a register with no enabled slot returns all ones, whatever the register file returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_used | input | 1 | Entry takes part in rebuilds |
| wr_is_fp | input | 1 | Entry class: 0 integer, 1 floating point |
| wr_key | input | 5 | Register the entry predicates |
| wr_src | input | 5 | Integer register holding the predicate |
| wr_inv | input | 1 | Complement the predicate |
| wr_zero | input | 1 | Zero masked-off elements |
| rebuild | input | 1 | Start rebuilding the tables |
| busy | output | 1 | Rebuild in progress |
| lk_is_fp | input | 1 | Lookup class: 0 integer, 1 floating point |
| lk_reg | input | 5 | Register number to look up |
| rf_addr | output | 5 | Integer register file read address |
| rf_data | input | 32 | Integer register file read data |
| lk_mask | output | 32 | Effective predicate mask |
| lk_zero | output | 1 | Zeroing flag of the matched entry |

## Verification
The assertions assume that the integer register file answers `rf_addr` within the same cycle. They also assume that `rebuild` and `wr_en` may arrive at any time, including while a rebuild is running. The bench models the register file as a combinational function of the address, so every lookup value is known in advance. It writes an entry and pulses `rebuild` in the middle of a rebuild to show that both are dropped. Lookups are made only while `busy` is low, because the tables are only partly built during a rebuild.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int REG_W    = 5;
  localparam int NUM_REGS = 1 << REG_W;

  typedef struct packed {
    logic             used;
    logic             is_fp;
    logic [REG_W-1:0] key;
    logic [REG_W-1:0] src;
    logic             inv;
    logic             zero;
  } slot_t;

  typedef struct packed {
    logic             en;
    logic [REG_W-1:0] src;
    logic             inv;
    logic             zero;
  } tab_t;
endpackage

// File: rtl/pm_slot_store.sv
module pm_slot_store
  import pm_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  slot_t            wr_slot,
  input  logic [IDX_W-1:0] rd_idx,
  output slot_t            rd_slot
);
  slot_t [NUM_SLOTS-1:0] slots;
  logic wr_take;

  assign wr_take = wr_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slots <= '0;
    else if (wr_take) slots[wr_idx] <= wr_slot;
  end

  assign rd_slot = slots[rd_idx];

  AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(slots)); // R10
endmodule

// File: rtl/pm_seq.sv
module pm_seq #(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rebuild,
  output logic             busy,
  output logic             clr,
  output logic             apply,
  output logic [IDX_W-1:0] apply_idx
);
  typedef enum logic [1:0] {S_IDLE, S_CLR, S_APPLY} st_t;
  st_t st;
  logic [IDX_W-1:0] cnt;
  logic apply_last;

  assign busy       = (st != S_IDLE);
  assign clr        = (st == S_CLR);
  assign apply      = (st == S_APPLY);
  assign apply_idx  = cnt;
  assign apply_last = apply && (cnt == IDX_W'(NUM_SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE:  if (rebuild) st <= S_CLR;
        S_CLR:   begin st <= S_APPLY; cnt <= '0; end
        S_APPLY: begin
          if (apply_last) st <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REBUILD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rebuild && !busy) |=> clr); // R3
  AST_BUSY_ENDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(apply_last)); // R3
endmodule

// File: rtl/pm_bank.sv
module pm_bank
  import pm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                wr,
  input  logic [REG_W-1:0]    wr_key,
  input  tab_t                wr_ent,
  input  logic [REG_W-1:0]    rd_key,
  output tab_t                rd_ent,
  output logic [NUM_REGS-1:0] en_vec
);
  tab_t [NUM_REGS-1:0] tab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tab <= '0;
    else if (clr) tab <= '0;
    else if (wr)  tab[wr_key] <= wr_ent;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_en
    assign en_vec[r] = tab[r].en;
  end

  assign rd_ent = tab[rd_key];

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (en_vec == '0)); // R4
endmodule

// File: rtl/pred_map_table.sv
module pred_map_table
  import pm_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int XLEN      = 32,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_used,
  input  logic             wr_is_fp,
  input  logic [REG_W-1:0] wr_key,
  input  logic [REG_W-1:0] wr_src,
  input  logic             wr_inv,
  input  logic             wr_zero,
  input  logic             rebuild,
  output logic             busy,
  input  logic             lk_is_fp,
  input  logic [REG_W-1:0] lk_reg,
  output logic [REG_W-1:0] rf_addr,
  input  logic [XLEN-1:0]  rf_data,
  output logic [XLEN-1:0]  lk_mask,
  output logic             lk_zero
);
  function automatic logic [XLEN-1:0] eff_mask(input logic en, input logic inv,
                                               input logic [XLEN-1:0] raw);
    if (!en)     return '1;
    else if (inv) return ~raw;
    else          return raw;
  endfunction

  slot_t            wr_slot, cur_slot;
  logic             clr, apply;
  logic [IDX_W-1:0] apply_idx;
  tab_t             apply_ent;
  tab_t             bank_rd [2];
  logic [NUM_REGS-1:0] bank_en [2];
  tab_t             sel;

  assign wr_slot = '{used: wr_used, is_fp: wr_is_fp, key: wr_key,
                     src: wr_src, inv: wr_inv, zero: wr_zero};

  pm_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk(clk), .rst_n(rst_n), .rebuild(rebuild), .busy(busy),
    .clr(clr), .apply(apply), .apply_idx(apply_idx)
  );

  pm_slot_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_slot(wr_slot), .rd_idx(apply_idx), .rd_slot(cur_slot)
  );

  assign apply_ent = '{en: 1'b1, src: cur_slot.src, inv: cur_slot.inv,
                       zero: cur_slot.zero};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = apply && cur_slot.used && (cur_slot.is_fp == 1'(b));
    pm_bank u_bank (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr(bank_wr),
      .wr_key(cur_slot.key), .wr_ent(apply_ent), .rd_key(lk_reg),
      .rd_ent(bank_rd[b]), .en_vec(bank_en[b])
    );
  end

  assign sel     = bank_rd[lk_is_fp];
  assign rf_addr = sel.src;
  assign lk_mask = eff_mask(sel.en, sel.inv, rf_data);
  assign lk_zero = sel.en & sel.zero;

  AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(bank_en[0]) && $stable(bank_en[1]))); // R2
endmodule

// File: tb/sim_pred_map_table.sv
module sim_pred_map_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_used = 1'b0, wr_is_fp = 1'b0, wr_inv = 1'b0, wr_zero = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [4:0]  wr_key = '0, wr_src = '0, lk_reg = '0;
  logic        rebuild = 1'b0, lk_is_fp = 1'b0;
  logic        busy, lk_zero;
  logic [4:0]  rf_addr;
  logic [31:0] rf_data, lk_mask;
  int          tests = 0, fails = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] rf_model(input logic [4:0] a);
    return {8'hC3, 3'b000, a, 8'h5A, 3'b000, a};
  endfunction
  assign rf_data = rf_model(rf_addr);

  pred_map_table u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_used(wr_used),
    .wr_is_fp(wr_is_fp), .wr_key(wr_key), .wr_src(wr_src), .wr_inv(wr_inv),
    .wr_zero(wr_zero), .rebuild(rebuild), .busy(busy), .lk_is_fp(lk_is_fp),
    .lk_reg(lk_reg), .rf_addr(rf_addr), .rf_data(rf_data), .lk_mask(lk_mask),
    .lk_zero(lk_zero)
  );

  typedef struct packed {
    logic       fp;
    logic [4:0] rg;
    logic       hit;
    logic [4:0] src;
    logic       inv;
    logic       zero;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd3,  1'b1, 5'd10, 1'b0, 1'b1, 4'd5},  // R5 R9
    '{1'b1, 5'd3,  1'b1, 5'd12, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 5'd5,  1'b1, 5'd11, 1'b1, 1'b0, 4'd6},  // R6
    '{1'b1, 5'd5,  1'b0, 5'd0,  1'b0, 1'b0, 4'd7},  // R7 class kept apart
    '{1'b0, 5'd7,  1'b1, 5'd14, 1'b1, 1'b1, 4'd8},  // R8 higher index wins
    '{1'b0, 5'd20, 1'b0, 5'd0,  1'b0, 1'b0, 4'd4},  // R4 unused entry
    '{1'b1, 5'd31, 1'b1, 5'd0,  1'b1, 1'b1, 4'd6},  // R6 top key, src 0
    '{1'b0, 5'd31, 1'b0, 5'd0,  1'b0, 1'b0, 4'd11}, // R11
    '{1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 4'd11}  // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic u, input logic fp, input int key,
                     input int src, input logic inv, input logic z);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_used = u; wr_is_fp = fp;
    wr_key = 5'(key); wr_src = 5'(src); wr_inv = inv; wr_zero = z;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic fp, input int rg);
    lk_is_fp = fp; lk_reg = 5'(rg);
    #1;
  endtask

  task automatic do_rebuild(output int cycles, input logic poke);
    @(negedge clk);
    rebuild = 1'b1;
    @(negedge clk);
    rebuild = 1'b0;
    cycles = 0;
    while (busy && cycles < 100) begin
      if (poke && cycles == 5) begin
        wr_en = 1'b1; wr_idx = 4'd6; wr_used = 1'b1; wr_is_fp = 1'b0;
        wr_key = 5'd25; wr_src = 5'd9; wr_inv = 1'b0; wr_zero = 1'b1;
        rebuild = 1'b1;
      end else begin
        wr_en = 1'b0; rebuild = 1'b0;
      end
      cycles++;
      @(negedge clk);
    end
    wr_en = 1'b0; rebuild = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    look(1'b0, 3);
    check("R1 mask", lk_mask, 32'hFFFF_FFFF);
    check("R1 zero", 32'(lk_zero), 32'd0);

    put(0,  1, 0, 3,  10, 0, 1);
    put(1,  1, 0, 5,  11, 1, 0);
    put(2,  1, 1, 3,  12, 0, 0);
    put(3,  1, 0, 7,  13, 0, 0);
    put(9,  1, 0, 7,  14, 1, 1);
    put(4,  0, 0, 20, 15, 0, 0);
    put(15, 1, 1, 31, 0,  1, 1);
    // R2 no effect before rebuild
    look(1'b0, 3);
    check("R2 mask before rebuild", lk_mask, 32'hFFFF_FFFF);

    do_rebuild(n, 1'b1);
    check("R3 busy cycles", 32'(n), 32'd17);
    check("R3 busy low after", 32'(busy), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] em;
      look(VECS[i].fp, int'(VECS[i].rg));
      if (!VECS[i].hit) em = '1;
      else if (VECS[i].inv) em = ~rf_model(VECS[i].src);
      else em = rf_model(VECS[i].src);
      check($sformatf("R%0d mask v%0d", VECS[i].req, i), lk_mask, em);
      check($sformatf("R%0d zero v%0d", VECS[i].req, i), 32'(lk_zero),
            32'(VECS[i].hit & VECS[i].zero));
      if (VECS[i].hit)
        check($sformatf("R%0d rf_addr v%0d", VECS[i].req, i), 32'(rf_addr), 32'(VECS[i].src));
    end

    // R10 write during busy dropped, even after another rebuild
    do_rebuild(n, 1'b0);
    check("R10 rebuild length", 32'(n), 32'd17);
    look(1'b0, 25);
    check("R10 write in busy ignored", lk_mask, 32'hFFFF_FFFF);
    check("R10 zero", 32'(lk_zero), 32'd0);

    // R4 disabling an entry reverts its key after rebuild
    put(0, 0, 0, 3, 10, 0, 1);
    look(1'b0, 3);
    check("R2 old mapping kept", lk_mask, rf_model(5'd10));
    do_rebuild(n, 1'b0);
    look(1'b0, 3);
    check("R4 cleared mask", lk_mask, 32'hFFFF_FFFF);
    check("R4 cleared zero", 32'(lk_zero), 32'd0);
    look(1'b1, 3);
    check("R7 fp key 3 kept", lk_mask, rf_model(5'd12));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule